// File: doc/BRIEF.md
# Supply-Loss Retention Sequencer

This block sits between a static-RAM controller and the RAM's control pins. A comparator outside the block reports whether the supply is above its threshold. When that report goes low, the block forces the RAM into its deselected data-retention state and holds the write strobe inactive. It does this in the same cycle that the synchronised report falls, so the retention state is already in place before the supply drops through its lower operating limit. Any access in progress at that moment is cut off. The RAM keeps its contents while deselected, down to a much lower retention voltage.

When the supply report comes back, it must stay high for a debounce window. A recovery hold-off, counted in clock cycles, then runs before the controller's signals are passed to the RAM again. If the supply report drops at any point during the hold-off, the count starts over. A ready output tells the controller when the memory may be used. A build-time parameter chooses which RAM pin keeps the device deselected: both byte enables, the active-low chip select, or the active-high chip select. Each choice comes with its own rule for the other select pins.

Top module: `retention_guard`

## Requirements
- R1: During reset and right after it, `mem_ready` is 0 and the RAM pins are in the retention state for the selected mode, with `ram_we_n` at 1.
- R2: If `supply_ok_raw` falls while the block is ready, `mem_ready` drops and the retention state is applied exactly SYNC_STAGES clock edges later. `mem_ready` stays low while `supply_ok_raw` is low.
- R3: In the same cycle as the deselect, `ram_we_n` is forced to 1 whatever `ctl_we_n` is, so a write in progress is aborted. It stays at 1 whenever `mem_ready` is 0.
- R4: A rise of `supply_ok_raw` that lasts fewer than DEBOUNCE cycles after synchronisation does not start recovery. `mem_ready` stays 0.
- R5: After `supply_ok_raw` rises and stays high, `mem_ready` goes to 1 at the clock edge SYNC_STAGES+DEBOUNCE+RECOVERY_CYCLES+1 edges after the rise.
- R6: A low pulse on `supply_ok_raw` during the recovery hold-off restarts the full sequence. `mem_ready` then rises SYNC_STAGES+DEBOUNCE+RECOVERY_CYCLES+1 edges after the supply returns.
- R7: With MODE=HOLD_BYTES, retention drives `ram_be_n` to all ones, `ram_cs1_n` to 1 and `ram_cs2` to 1.
- R8: With MODE=HOLD_CS1, retention drives `ram_cs1_n` to 1 and holds `ram_cs2` at 1. `ram_be_n` follows `ctl_be_n`.
- R9: With MODE=HOLD_CS2, retention drives `ram_cs2` to 0. `ram_cs1_n` and `ram_be_n` follow the controller.
- R10: While `mem_ready` is 1, every RAM pin equals the matching controller signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for synchroniser, debounce and recovery count |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| supply_ok_raw | input | 1 | Asynchronous comparator output, 1 = supply above threshold |
| ctl_cs1_n | input | 1 | Controller's active-low chip select |
| ctl_cs2 | input | 1 | Controller's active-high chip select |
| ctl_be_n | input | LANES | Controller's active-low byte enables |
| ctl_we_n | input | 1 | Controller's active-low write strobe |
| ram_cs1_n | output | 1 | Active-low chip select to the RAM |
| ram_cs2 | output | 1 | Active-high chip select to the RAM |
| ram_be_n | output | LANES | Active-low byte enables to the RAM |
| ram_we_n | output | 1 | Active-low write strobe to the RAM |
| mem_ready | output | 1 | 1 = memory may be accessed |

## Verification
The assertions check on every cycle that the pins pass through unchanged while ready and that the write strobe stays off while not ready. They also check the per-mode retention levels, that ready is low once the raw supply report has been low for SYNC_STAGES edges, and that ready never rises before the supply has been high for at least the recovery length. Only the bench scenarios can show the exact cycle on which ready returns, the rejection of a short supply glitch, and the full restart of the count after a dip during recovery.

// File: rtl/retn_pkg.sv
package retn_pkg;
  typedef enum logic [1:0] {
    HOLD_BYTES = 2'd0,
    HOLD_CS1   = 2'd1,
    HOLD_CS2   = 2'd2
  } hold_mode_e;

  typedef enum logic [1:0] {
    ST_RETAIN  = 2'd0,
    ST_RECOVER = 2'd1,
    ST_ACTIVE  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/retn_sync_filter.sv
module retn_sync_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEBOUNCE    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_ok,
  output logic sync_ok,
  output logic filt_ok
);
  localparam int unsigned DW = $clog2(DEBOUNCE + 1);
  localparam logic [DW-1:0] DEB_LIM = DW'(DEBOUNCE);

  logic [SYNC_STAGES-1:0] chain_q, chain_d;
  logic [DW-1:0]          deb_q, deb_d;
  logic                   deb_en;

  // synchroniser shift path
  always_comb begin
    chain_d = {chain_q[SYNC_STAGES-2:0], raw_ok};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_ok = chain_q[SYNC_STAGES-1];

  // rising side debounced, falling side immediate
  always_comb begin
    deb_en = !sync_ok || (deb_q != DEB_LIM);
    deb_d  = sync_ok ? deb_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      deb_q <= '0;
    else if (deb_en) deb_q <= deb_d;
  end

  assign filt_ok = sync_ok && (deb_q == DEB_LIM);
endmodule

// File: rtl/retn_seq_fsm.sv
module retn_seq_fsm
  import retn_pkg::*;
#(
  parameter int unsigned RECOVERY_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_ok,
  input  logic filt_ok,
  output logic hold
);
  localparam int unsigned RW = (RECOVERY_CYCLES > 2) ? $clog2(RECOVERY_CYCLES) : 1;
  localparam logic [RW-1:0] CNT_LAST = RW'(RECOVERY_CYCLES - 1);

  seq_state_e    st_q, st_d;
  logic [RW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_RETAIN: begin
        if (filt_ok) begin
          st_d  = ST_RECOVER;
          cnt_d = '0;
        end
      end
      ST_RECOVER: begin
        if (!filt_ok)              st_d  = ST_RETAIN;
        else if (cnt_q == CNT_LAST) st_d = ST_ACTIVE;
        else                       cnt_d = cnt_q + 1'b1;
      end
      ST_ACTIVE: begin
        if (!filt_ok) st_d = ST_RETAIN;
      end
      default: st_d = ST_RETAIN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RETAIN;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // sync_ok is a flop output: deselect in the same cycle it falls
  assign hold = (st_q != ST_ACTIVE) || !sync_ok;
endmodule

// File: rtl/retn_pin_override.sv
module retn_pin_override
  import retn_pkg::*;
#(
  parameter hold_mode_e  MODE  = HOLD_BYTES,
  parameter int unsigned LANES = 2
) (
  input  logic             hold,
  input  logic             ctl_cs1_n,
  input  logic             ctl_cs2,
  input  logic [LANES-1:0] ctl_be_n,
  input  logic             ctl_we_n,
  output logic             ram_cs1_n,
  output logic             ram_cs2,
  output logic [LANES-1:0] ram_be_n,
  output logic             ram_we_n
);
  assign ram_we_n = hold | ctl_we_n;

  generate
    if (MODE == HOLD_BYTES) begin : g_bytes
      always_comb begin
        ram_be_n  = hold ? '1   : ctl_be_n;
        ram_cs1_n = hold ? 1'b1 : ctl_cs1_n;
        ram_cs2   = hold ? 1'b1 : ctl_cs2;
      end
    end else if (MODE == HOLD_CS1) begin : g_cs1
      always_comb begin
        ram_be_n  = ctl_be_n;
        ram_cs1_n = hold ? 1'b1 : ctl_cs1_n;
        ram_cs2   = hold ? 1'b1 : ctl_cs2;
      end
    end else begin : g_cs2
      always_comb begin
        ram_be_n  = ctl_be_n;
        ram_cs1_n = ctl_cs1_n;
        ram_cs2   = hold ? 1'b0 : ctl_cs2;
      end
    end
  endgenerate
endmodule

// File: rtl/retention_guard.sv
module retention_guard
  import retn_pkg::*;
#(
  parameter hold_mode_e  MODE            = HOLD_BYTES,
  parameter int unsigned LANES           = 2,
  parameter int unsigned SYNC_STAGES     = 2,
  parameter int unsigned DEBOUNCE        = 4,
  parameter int unsigned RECOVERY_CYCLES = 250000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok_raw,
  input  logic             ctl_cs1_n,
  input  logic             ctl_cs2,
  input  logic [LANES-1:0] ctl_be_n,
  input  logic             ctl_we_n,
  output logic             ram_cs1_n,
  output logic             ram_cs2,
  output logic [LANES-1:0] ram_be_n,
  output logic             ram_we_n,
  output logic             mem_ready
);
  logic sync_ok, filt_ok, hold;

  retn_sync_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEBOUNCE   (DEBOUNCE)
  ) filt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_ok (supply_ok_raw),
    .sync_ok(sync_ok),
    .filt_ok(filt_ok)
  );

  retn_seq_fsm #(
    .RECOVERY_CYCLES(RECOVERY_CYCLES)
  ) seq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_ok(sync_ok),
    .filt_ok(filt_ok),
    .hold   (hold)
  );

  retn_pin_override #(
    .MODE (MODE),
    .LANES(LANES)
  ) pins_i (
    .hold     (hold),
    .ctl_cs1_n(ctl_cs1_n),
    .ctl_cs2  (ctl_cs2),
    .ctl_be_n (ctl_be_n),
    .ctl_we_n (ctl_we_n),
    .ram_cs1_n(ram_cs1_n),
    .ram_cs2  (ram_cs2),
    .ram_be_n (ram_be_n),
    .ram_we_n (ram_we_n)
  );

  assign mem_ready = !hold;
endmodule

// File: rtl/retention_guard_chk.sv
module retention_guard_chk
  import retn_pkg::*;
#(
  parameter hold_mode_e  MODE            = HOLD_BYTES,
  parameter int unsigned LANES           = 2,
  parameter int unsigned SYNC_STAGES     = 2,
  parameter int unsigned RECOVERY_CYCLES = 250000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             supply_ok_raw,
  input logic             ctl_cs1_n,
  input logic             ctl_cs2,
  input logic [LANES-1:0] ctl_be_n,
  input logic             ctl_we_n,
  input logic             ram_cs1_n,
  input logic             ram_cs2,
  input logic [LANES-1:0] ram_be_n,
  input logic             ram_we_n,
  input logic             mem_ready
);
  logic [31:0] low_run_q, high_run_q;

  // consecutive sampled-low / sampled-high run lengths, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q  <= '0;
      high_run_q <= '0;
    end else begin
      if (supply_ok_raw) low_run_q <= '0;
      else if (low_run_q != 32'(SYNC_STAGES)) low_run_q <= low_run_q + 1;
      if (!supply_ok_raw) high_run_q <= '0;
      else if (high_run_q != 32'hFFFF_FFFF) high_run_q <= high_run_q + 1;
    end
  end

  assert_pass_through_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready |-> (ram_cs1_n == ctl_cs1_n && ram_cs2 == ctl_cs2 &&
                   ram_be_n == ctl_be_n && ram_we_n == ctl_we_n));

  assert_strobe_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ready |-> ram_we_n);

  assert_drop_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (low_run_q == 32'(SYNC_STAGES)) |-> !mem_ready);

  assert_recovery_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ready) |-> (high_run_q >= 32'(RECOVERY_CYCLES)));

  generate
    if (MODE == HOLD_BYTES) begin : g_bytes
      assert_bytes_levels_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ready |-> (ram_be_n == '1 && ram_cs1_n && ram_cs2));
    end else if (MODE == HOLD_CS1) begin : g_cs1
      assert_cs1_levels_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ready |-> (ram_cs1_n && ram_cs2 && ram_be_n == ctl_be_n));
    end else begin : g_cs2
      assert_cs2_levels_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ready |-> (!ram_cs2 && ram_cs1_n == ctl_cs1_n && ram_be_n == ctl_be_n));
    end
  endgenerate
endmodule

bind retention_guard retention_guard_chk #(
  .MODE           (MODE),
  .LANES          (LANES),
  .SYNC_STAGES    (SYNC_STAGES),
  .RECOVERY_CYCLES(RECOVERY_CYCLES)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .supply_ok_raw(supply_ok_raw),
  .ctl_cs1_n    (ctl_cs1_n),
  .ctl_cs2      (ctl_cs2),
  .ctl_be_n     (ctl_be_n),
  .ctl_we_n     (ctl_we_n),
  .ram_cs1_n    (ram_cs1_n),
  .ram_cs2      (ram_cs2),
  .ram_be_n     (ram_be_n),
  .ram_we_n     (ram_we_n),
  .mem_ready    (mem_ready)
);

// File: tb/retention_guard_tb_top.sv
module retention_guard_tb_top;
  import retn_pkg::*;

  localparam int SYNC = 2;
  localparam int DEB  = 4;
  localparam int REC  = 40;
  localparam int READY_LAT = SYNC + DEB + REC + 1;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       raw;
  logic       c_cs1_n, c_cs2, c_we_n;
  logic [1:0] c_be_n;

  logic       b_cs1_n, b_cs2, b_we_n, b_rdy;
  logic [1:0] b_be_n;
  logic       s1_cs1_n, s1_cs2, s1_we_n, s1_rdy;
  logic [1:0] s1_be_n;
  logic       s2_cs1_n, s2_cs2, s2_we_n, s2_rdy;
  logic [1:0] s2_be_n;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  retention_guard #(.MODE(HOLD_BYTES), .LANES(2), .SYNC_STAGES(SYNC),
                    .DEBOUNCE(DEB), .RECOVERY_CYCLES(REC)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok_raw(raw),
    .ctl_cs1_n(c_cs1_n), .ctl_cs2(c_cs2), .ctl_be_n(c_be_n), .ctl_we_n(c_we_n),
    .ram_cs1_n(b_cs1_n), .ram_cs2(b_cs2), .ram_be_n(b_be_n), .ram_we_n(b_we_n),
    .mem_ready(b_rdy));

  retention_guard #(.MODE(HOLD_CS1), .LANES(2), .SYNC_STAGES(SYNC),
                    .DEBOUNCE(DEB), .RECOVERY_CYCLES(REC)) dut_s1_i (
    .clk(clk), .rst_n(rst_n), .supply_ok_raw(raw),
    .ctl_cs1_n(c_cs1_n), .ctl_cs2(c_cs2), .ctl_be_n(c_be_n), .ctl_we_n(c_we_n),
    .ram_cs1_n(s1_cs1_n), .ram_cs2(s1_cs2), .ram_be_n(s1_be_n), .ram_we_n(s1_we_n),
    .mem_ready(s1_rdy));

  retention_guard #(.MODE(HOLD_CS2), .LANES(2), .SYNC_STAGES(SYNC),
                    .DEBOUNCE(DEB), .RECOVERY_CYCLES(REC)) dut_s2_i (
    .clk(clk), .rst_n(rst_n), .supply_ok_raw(raw),
    .ctl_cs1_n(c_cs1_n), .ctl_cs2(c_cs2), .ctl_be_n(c_be_n), .ctl_we_n(c_we_n),
    .ram_cs1_n(s2_cs1_n), .ram_cs2(s2_cs2), .ram_be_n(s2_be_n), .ram_we_n(s2_we_n),
    .mem_ready(s2_rdy));

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // pin vector {cs1_n, cs2, be_n[1:0], we_n}
  function automatic int pins(input logic a, input logic b, input logic [1:0] c, input logic d);
    return int'({a, b, c, d});
  endfunction

  task automatic check_held(input string tag);
    check({tag, " R7 bytes mode"}, pins(b_cs1_n, b_cs2, b_be_n, b_we_n), pins(1'b1, 1'b1, 2'b11, 1'b1));
    check({tag, " R8 cs1 mode"}, pins(s1_cs1_n, s1_cs2, s1_be_n, s1_we_n), pins(1'b1, 1'b1, c_be_n, 1'b1));
    check({tag, " R9 cs2 mode"}, pins(s2_cs1_n, s2_cs2, s2_be_n, s2_we_n), pins(c_cs1_n, 1'b0, c_be_n, 1'b1));
    check({tag, " R2 ready low"}, int'({b_rdy, s1_rdy, s2_rdy}), 0);
  endtask

  task automatic check_passing(input string tag);
    int exp_v;
    exp_v = pins(c_cs1_n, c_cs2, c_be_n, c_we_n);
    check({tag, " R10 bytes"}, pins(b_cs1_n, b_cs2, b_be_n, b_we_n), exp_v);
    check({tag, " R10 cs1"}, pins(s1_cs1_n, s1_cs2, s1_be_n, s1_we_n), exp_v);
    check({tag, " R10 cs2"}, pins(s2_cs1_n, s2_cs2, s2_be_n, s2_we_n), exp_v);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      n++;
      if (b_rdy) break;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; raw = 1'b0;
    c_cs1_n = 1'b0; c_cs2 = 1'b1; c_be_n = 2'b10; c_we_n = 1'b0;
    repeat (3) @(negedge clk);
    check_held("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_held("R1 after reset");
  endtask

  task automatic t_power_up;
    int n;
    raw = 1'b1;
    wait_ready(n);
    check("R5 ready latency", n, READY_LAT);
    check("R5 all modes ready", int'({b_rdy, s1_rdy, s2_rdy}), 3'b111);
    check_passing("R5 active");
    c_be_n = 2'b01; c_cs2 = 1'b0;
    @(negedge clk);
    check_passing("R10 changed inputs");
    c_be_n = 2'b10; c_cs2 = 1'b1;
  endtask

  task automatic t_power_drop;
    c_we_n = 1'b0;
    raw = 1'b0;
    @(negedge clk);
    check("R2 still ready one edge after fall", int'(b_rdy), 1);
    check("R3 strobe passes before deselect", int'(b_we_n), 0);
    @(negedge clk);
    check("R3 strobe forced with deselect", int'(b_we_n), 1);
    check_held("R2 drop");
    repeat (10) @(negedge clk);
    check_held("R2 stays held");
  endtask

  task automatic t_glitch_rise;
    raw = 1'b1;
    repeat (3) @(negedge clk);
    raw = 1'b0;
    repeat (60) @(negedge clk);
    check("R4 short rise ignored", int'(b_rdy), 0);
    check_held("R4 short rise");
  endtask

  task automatic t_recovery_restart;
    int n;
    raw = 1'b1;
    repeat (20) @(negedge clk);
    check("R6 mid-recovery not ready", int'(b_rdy), 0);
    raw = 1'b0;
    @(negedge clk);
    raw = 1'b1;
    wait_ready(n);
    check("R6 restarted latency", n, READY_LAT);
    check_passing("R6 active");
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_power_up();
    t_power_drop();
    t_glitch_rise();
    t_recovery_restart();
    t_power_drop();
    summary();
  end
endmodule